// File: doc/BRIEF.md
# Programmable Timer Counter Core

This block is a single timer counter whose width is set by a parameter (16 or 32 bits in practice). A power-of-two prescaler sets how often the counter steps. A mode field selects counting up, counting down, or counting up and then down. The point where the counter wraps or turns around is held in an active top register. That register can be written directly, or through a buffer that is copied into it only when the next wrap event occurs. Optional one-shot and double-step behaviour complete the counting options.

The counter is started, stopped and reloaded by two sources: single-cycle software commands, and a per-edge action table applied to an external, already-synchronised input. A direct counter write places a value in the count at any time. The outputs are the count value, the current direction, one-cycle overflow and underflow strobes, and a running flag.

Top module: `tmr_core`

## Requirements
- R1: After reset the count is 0, the active top and the top buffer hold the maximum count (all ones, 0xFFFF at the default 16-bit width), the counter is stopped, direction is up (dir=0), and ovf/udf are low.
- R2: With prescale select n (values above 10 act as 10), a running counter takes one step every 2^n clocks. The first step lands 2^n clocks after the cycle in which running first reads 1. The prescaler is cleared while the counter is stopped and on a reload.
- R3: When double-step is set, each step moves the count by 2 instead of 1. An up step never goes past top and a down step never goes below 0.
- R4: Mode code 0 (up): a step taken with the count at or above top sets the count to 0 and pulses ovf for one cycle, in the same cycle that the 0 appears. Any other step adds the step size.
- R5: Mode code 1 (down): a step taken at 0 loads top and pulses udf for one cycle. Any other step subtracts the step size.
- R6: Mode code 2 (up/down): counting up, a step at or above top reverses to down, pulses ovf and moves the count to top minus the step (floored at 0). Counting down, a step at 0 reverses to up, pulses udf and moves the count to the step size (capped at top). dir reads 1 while counting down. ovf and udf are never high together.
- R7: A top-buffer write is copied into the active top on the next ovf or udf event. On a down wrap, the copied value is the one loaded into the count. A direct top write takes effect on the next cycle and cancels any pending buffered value.
- R8: With one-shot set, the counter stops at its first wrap: at 0 in up mode, at top in down mode, and at 0 on the underflow that ends an up/down sweep.
- R9: The rising and falling edges of trig_in each have their own 2-bit action: 0 none, 1 start, 2 stop, 3 reload and start. The action appears in the outputs one clock after the edge is sampled.
- R10: A reload sets the count to 0 when the current direction is up and to the active top when it is down. A reload takes precedence over a step in the same cycle.
- R11: sw_start and sw_stop take effect on the next cycle. Any stop request (software or edge) wins over any start in the same cycle, and also blocks a reload. A stopped counter keeps its count.
- R12: A counter write loads cnt_wdata on the next cycle. It takes precedence over reloads and steps, and produces no ovf/udf. It does not change whether the counter runs.
- R13: Mode code 3 is reserved. In that mode the count holds even while the counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Counting mode: 0 up, 1 down, 2 up/down, 3 reserved |
| cfg_presc | input | 4 | Prescale exponent n; the step rate is clk/2^n |
| cfg_one_shot | input | 1 | Stop at the first wrap |
| cfg_dbl | input | 1 | Step by 2 |
| cfg_rise_act | input | 2 | Action on a rising edge of trig_in |
| cfg_fall_act | input | 2 | Action on a falling edge of trig_in |
| trig_in | input | 1 | External trigger, already synchronous to clk |
| sw_start | input | 1 | Software start command (one-cycle pulse) |
| sw_stop | input | 1 | Software stop command (one-cycle pulse) |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_wdata | input | CNT_W | Value for a counter write |
| top_wr | input | 1 | Direct top write strobe |
| top_wdata | input | CNT_W | Value for a direct top write |
| topb_wr | input | 1 | Top buffer write strobe |
| topb_wdata | input | CNT_W | Value for the top buffer |
| count | output | CNT_W | Current count |
| dir | output | 1 | 1 while counting down |
| ovf | output | 1 | One-cycle overflow strobe |
| udf | output | 1 | One-cycle underflow strobe |
| running | output | 1 | Counter is running |

## Verification
Every command, edge action and write is registered once, so count, running, ovf and udf show its effect exactly one clock after the edge that samples it. Prescaled steps appear 2^n clocks after running rises, and dir follows the mode field in the same cycle. The bench drives inputs on the falling edge, and a behavioural reference model advances on the rising edge from the same sampled inputs. Every output is compared with the model on the next falling edge, so each comparison sees precisely the cycle in which a result is due. A few fixed-value checks at known points back the model up.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_RSVD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_START  = 2'd1,
        ACT_STOP   = 2'd2,
        ACT_RELOAD = 2'd3
    } edge_act_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int LOG_MAX = 10,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = LOG_MAX;

    typedef struct packed {
        logic [CW-1:0] pre;
    } pst_t;

    pst_t s_d, s_q;
    logic [SEL_W-1:0] sel_c;
    logic [CW-1:0]    mask;

    always_comb begin
        sel_c = (int'(sel) > LOG_MAX) ? SEL_W'(LOG_MAX) : sel;
        mask  = ~({CW{1'b1}} << sel_c);
        tick  = run && ((s_q.pre & mask) == mask);
        s_d   = s_q;
        if (!run || restart) s_d.pre = '0;
        else                 s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_trigger.sv
module tmr_trigger
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] rise_act,
    input  logic [1:0] fall_act,
    input  logic       sw_start,
    input  logic       sw_stop,
    output logic       start_req,
    output logic       stop_req,
    output logic       reload_req
);
    typedef struct packed {
        logic trig;
    } tst_t;

    tst_t      s_d, s_q;
    edge_act_e act;
    logic      rise, fall;

    always_comb begin
        rise = trig_in && !s_q.trig;
        fall = !trig_in && s_q.trig;
        if (rise)      act = edge_act_e'(rise_act);
        else if (fall) act = edge_act_e'(fall_act);
        else           act = ACT_NONE;
        // any stop source outranks every start source and blocks reload
        stop_req   = sw_stop || (act == ACT_STOP);
        start_req  = !stop_req && (sw_start || act == ACT_START || act == ACT_RELOAD);
        reload_req = !stop_req && (act == ACT_RELOAD);
        s_d.trig   = trig_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_mode_e    mode,
    input  logic         one_shot,
    input  logic         dbl,
    input  logic         tick,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic         reload_req,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         top_wr,
    input  logic [W-1:0] top_wdata,
    input  logic         topb_wr,
    input  logic [W-1:0] topb_wdata,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         dir,
    output logic         ovf,
    output logic         udf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] top;
        logic [W-1:0] topb;
        logic         pend;
        logic         run;
        logic         dir;
        logic         ovf;
        logic         udf;
    } cst_t;

    cst_t s_d, s_q;

    logic         eff_dir;
    logic [W-1:0] step;
    logic [W-1:0] wrap_top;
    logic [W:0]   sum_up;
    logic [W-1:0] sat_up;
    logic [W-1:0] sat_dn;
    logic         os_end;

    always_comb begin
        eff_dir  = (mode == MODE_UPDOWN) ? s_q.dir : (mode == MODE_DOWN);
        step     = dbl ? W'(2) : W'(1);
        wrap_top = s_q.pend ? s_q.topb : s_q.top;
        sum_up   = {1'b0, s_q.cnt} + {1'b0, step};
        sat_up   = (sum_up > {1'b0, s_q.top}) ? s_q.top : sum_up[W-1:0];
        sat_dn   = (s_q.cnt < step) ? '0 : (s_q.cnt - step);
        os_end   = 1'b0;

        s_d      = s_q;
        s_d.ovf  = 1'b0;
        s_d.udf  = 1'b0;
        s_d.dir  = (mode == MODE_UPDOWN) ? s_q.dir : (mode == MODE_DOWN);

        if (cnt_wr) begin
            s_d.cnt = cnt_wdata;
        end else if (reload_req) begin
            s_d.cnt = eff_dir ? s_q.top : '0;
        end else if (tick) begin
            unique case (mode)
                MODE_UP: begin
                    if (s_q.cnt >= s_q.top) begin
                        s_d.cnt = '0;
                        s_d.ovf = 1'b1;
                        os_end  = one_shot;
                    end else begin
                        s_d.cnt = sat_up;
                    end
                end
                MODE_DOWN: begin
                    if (s_q.cnt == '0) begin
                        s_d.cnt = wrap_top;
                        s_d.udf = 1'b1;
                        os_end  = one_shot;
                    end else begin
                        s_d.cnt = sat_dn;
                    end
                end
                MODE_UPDOWN: begin
                    if (!s_q.dir) begin
                        if (s_q.cnt >= s_q.top) begin
                            s_d.ovf = 1'b1;
                            s_d.dir = 1'b1;
                            s_d.cnt = (s_q.top > step) ? (s_q.top - step) : '0;
                        end else begin
                            s_d.cnt = sat_up;
                        end
                    end else begin
                        if (s_q.cnt == '0) begin
                            s_d.udf = 1'b1;
                            s_d.dir = 1'b0;
                            os_end  = one_shot;
                            if (one_shot)             s_d.cnt = '0;
                            else if (step > wrap_top) s_d.cnt = wrap_top;
                            else                      s_d.cnt = step;
                        end else begin
                            s_d.cnt = sat_dn;
                        end
                    end
                end
                default: s_d.cnt = s_q.cnt;
            endcase
        end

        // buffered top moves over on a wrap event
        if ((s_d.ovf || s_d.udf) && s_q.pend) begin
            s_d.top  = s_q.topb;
            s_d.pend = 1'b0;
        end
        if (top_wr) begin
            s_d.top  = top_wdata;
            s_d.pend = 1'b0;
        end
        if (topb_wr) begin
            s_d.topb = topb_wdata;
            s_d.pend = 1'b1;
        end

        if (stop_req)       s_d.run = 1'b0;
        else if (start_req) s_d.run = 1'b1;
        else if (os_end)    s_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.top  <= '1;
            s_q.topb <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign run = s_q.run;
    assign dir = eff_dir;
    assign ovf = s_q.ovf;
    assign udf = s_q.udf;

    // R4: an up step taken at top wraps to zero with an overflow strobe
    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && s_q.cnt == s_q.top && !cnt_wr && !reload_req)
        |=> (s_q.ovf && s_q.cnt == '0));

    // R5: a down step taken at zero raises underflow
    assert_down_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DOWN && s_q.cnt == '0 && !cnt_wr && !reload_req)
        |=> s_q.udf);

    // R8: one-shot up counting stops at its wrap
    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && one_shot && mode == MODE_UP && s_q.cnt >= s_q.top &&
         !cnt_wr && !reload_req && !start_req && !stop_req)
        |=> !s_q.run);

    // R11: a stopped counter keeps its value without a write or reload
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !cnt_wr && !reload_req) |=> $stable(s_q.cnt));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRESC_LOG = 10,
    parameter int PSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [PSEL_W-1:0] cfg_presc,
    input  logic              cfg_one_shot,
    input  logic              cfg_dbl,
    input  logic [1:0]        cfg_rise_act,
    input  logic [1:0]        cfg_fall_act,
    input  logic              trig_in,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              top_wr,
    input  logic [CNT_W-1:0]  top_wdata,
    input  logic              topb_wr,
    input  logic [CNT_W-1:0]  topb_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              dir,
    output logic              ovf,
    output logic              udf,
    output logic              running
);
    logic start_req, stop_req, reload_req;
    logic tick;

    tmr_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .rise_act   (cfg_rise_act),
        .fall_act   (cfg_fall_act),
        .sw_start   (sw_start),
        .sw_stop    (sw_stop),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .reload_req (reload_req)
    );

    tmr_prescaler #(
        .LOG_MAX (PRESC_LOG),
        .SEL_W   (PSEL_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (reload_req),
        .sel     (cfg_presc),
        .tick    (tick)
    );

    tmr_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cnt_mode_e'(cfg_mode)),
        .one_shot   (cfg_one_shot),
        .dbl        (cfg_dbl),
        .tick       (tick),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .reload_req (reload_req),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .top_wr     (top_wr),
        .top_wdata  (top_wdata),
        .topb_wr    (topb_wr),
        .topb_wdata (topb_wdata),
        .cnt        (count),
        .run        (running),
        .dir        (dir),
        .ovf        (ovf),
        .udf        (udf)
    );

    // R11: a software stop always leaves the counter stopped
    assert_stop_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !running);

    // R6: overflow and underflow never coincide
    assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && udf));

    // R2: a wrap strobe only follows a running cycle
    assert_event_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || udf) |-> $past(running));

endmodule

// File: tb/tmr_core_tb.sv
`timescale 1ns/1ps
module tmr_core_tb_top;
    localparam int  W    = 16;
    localparam longint MAXV = 65535;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic [3:0]   cfg_presc = 4'd0;
    logic         cfg_one_shot = 1'b0, cfg_dbl = 1'b0;
    logic [1:0]   cfg_rise_act = 2'd0, cfg_fall_act = 2'd0;
    logic         trig_in = 1'b0, sw_start = 1'b0, sw_stop = 1'b0;
    logic         cnt_wr = 1'b0, top_wr = 1'b0, topb_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0, top_wdata = '0, topb_wdata = '0;
    logic [W-1:0] count;
    logic         dir, ovf, udf, running;

    tmr_core #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_presc(cfg_presc),
        .cfg_one_shot(cfg_one_shot), .cfg_dbl(cfg_dbl),
        .cfg_rise_act(cfg_rise_act), .cfg_fall_act(cfg_fall_act),
        .trig_in(trig_in), .sw_start(sw_start), .sw_stop(sw_stop),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .top_wr(top_wr), .top_wdata(top_wdata),
        .topb_wr(topb_wr), .topb_wdata(topb_wdata),
        .count(count), .dir(dir), .ovf(ovf), .udf(udf), .running(running)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference state
    longint m_cnt, m_top, m_topb, m_pre;
    bit     m_pend, m_run, m_dir, m_ovf, m_udf, m_trig;
    longint n_cnt, n_top, n_topb, stepv, wt, per, psel;
    bit     n_pend, n_dir, ov, un, osend, edir, stp, sta, rel, tk;
    int     act;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_top = MAXV; m_topb = MAXV; m_pre = 0; m_pend = 0;
            m_run = 0; m_dir = 0; m_ovf = 0; m_udf = 0; m_trig = 0;
        end else begin
            psel = (cfg_presc > 10) ? 10 : cfg_presc;
            per  = longint'(1) << psel;
            edir = (cfg_mode == 2) ? m_dir : (cfg_mode == 1);
            if (trig_in && !m_trig)      act = cfg_rise_act;
            else if (!trig_in && m_trig) act = cfg_fall_act;
            else                         act = 0;
            stp = sw_stop || act == 2;
            sta = !stp && (sw_start || act == 1 || act == 3);
            rel = !stp && act == 3;
            tk  = m_run && ((m_pre % per) == per - 1);
            stepv = cfg_dbl ? 2 : 1;
            wt = m_pend ? m_topb : m_top;
            n_cnt = m_cnt; n_top = m_top; n_topb = m_topb; n_pend = m_pend;
            n_dir = (cfg_mode == 2) ? m_dir : (cfg_mode == 1);
            ov = 0; un = 0; osend = 0;
            if (cnt_wr) n_cnt = cnt_wdata;
            else if (rel) n_cnt = edir ? m_top : 0;
            else if (tk && cfg_mode != 3) begin
                if (cfg_mode == 0) begin
                    if (m_cnt >= m_top) begin n_cnt = 0; ov = 1; osend = cfg_one_shot; end
                    else n_cnt = (m_cnt + stepv > m_top) ? m_top : m_cnt + stepv;
                end else if (cfg_mode == 1) begin
                    if (m_cnt == 0) begin n_cnt = wt; un = 1; osend = cfg_one_shot; end
                    else n_cnt = (m_cnt < stepv) ? 0 : m_cnt - stepv;
                end else if (!m_dir) begin
                    if (m_cnt >= m_top) begin
                        ov = 1; n_dir = 1; n_cnt = (m_top > stepv) ? m_top - stepv : 0;
                    end else n_cnt = (m_cnt + stepv > m_top) ? m_top : m_cnt + stepv;
                end else begin
                    if (m_cnt == 0) begin
                        un = 1; n_dir = 0; osend = cfg_one_shot;
                        n_cnt = cfg_one_shot ? 0 : ((stepv > wt) ? wt : stepv);
                    end else n_cnt = (m_cnt < stepv) ? 0 : m_cnt - stepv;
                end
            end
            if ((ov || un) && m_pend) begin n_top = m_topb; n_pend = 0; end
            if (top_wr)  begin n_top = top_wdata; n_pend = 0; end
            if (topb_wr) begin n_topb = topb_wdata; n_pend = 1; end
            m_pre  = (!m_run || rel) ? 0 : m_pre + 1;
            if (stp) m_run = 0;
            else if (sta) m_run = 1;
            else if (osend) m_run = 0;
            m_cnt = n_cnt; m_top = n_top; m_topb = n_topb; m_pend = n_pend;
            m_dir = n_dir; m_ovf = ov; m_udf = un; m_trig = trig_in;
        end
    end

    task automatic chk(input string tag, input string what, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    task automatic cyc(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, "count", count, m_cnt);
            chk(tag, "running", running, m_run);
            chk(tag, "ovf", ovf, m_ovf);
            chk(tag, "udf", udf, m_udf);
            chk(tag, "dir", dir, (cfg_mode == 2) ? m_dir : (cfg_mode == 1));
            sw_start = 0; sw_stop = 0; cnt_wr = 0; top_wr = 0; topb_wr = 0;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(3, "R1");
        rst_n = 1;
        cyc(2, "R1");
        chk("R1", "count", count, 0);
        chk("R1", "running", running, 0);

        // R4 up counting with a small top, direct top write (R7)
        top_wr = 1; top_wdata = 5; cyc(1, "R7");
        sw_start = 1; cyc(16, "R4");

        // R2 prescaler, including an out-of-range select clamped to 10
        cfg_presc = 2; cyc(30, "R2");
        top_wr = 1; top_wdata = 2; cfg_presc = 13; cyc(3300, "R2");
        cfg_presc = 0;

        // R3 double step, up then down
        sw_stop = 1; cnt_wr = 1; cnt_wdata = 0; top_wr = 1; top_wdata = 5; cyc(1, "R3");
        cfg_dbl = 1; sw_start = 1; cyc(12, "R3");
        cfg_mode = 1; cyc(12, "R3");
        cfg_dbl = 0;

        // R5 down counting
        cyc(14, "R5");

        // R6 up/down sweeps, single and double step
        cfg_mode = 2; cyc(20, "R6");
        top_wr = 1; top_wdata = 6; cfg_dbl = 1; cyc(18, "R6");
        cfg_dbl = 0;

        // R7 buffered top and direct top override
        cfg_mode = 0; top_wr = 1; top_wdata = 9; topb_wr = 1; topb_wdata = 3; cyc(25, "R7");
        cfg_mode = 1; topb_wr = 1; topb_wdata = 7; cyc(20, "R7");
        topb_wr = 1; topb_wdata = 2; cyc(2, "R7");
        top_wr = 1; top_wdata = 12; cyc(30, "R7");

        // R8 one-shot in each mode
        cfg_one_shot = 1; cfg_mode = 0; sw_start = 1; cyc(20, "R8");
        sw_start = 1; cyc(20, "R8");
        cfg_mode = 1; sw_start = 1; cyc(20, "R8");
        cfg_mode = 2; sw_start = 1; cyc(40, "R8");
        cfg_one_shot = 0;

        // R9 edge actions: rise starts, fall stops
        sw_stop = 1; cfg_mode = 0; cyc(1, "R9");
        cfg_rise_act = 1; cfg_fall_act = 2;
        trig_in = 1; cyc(6, "R9");
        trig_in = 0; cyc(6, "R9");
        cfg_rise_act = 0; cfg_fall_act = 0;
        trig_in = 1; cyc(3, "R9");
        trig_in = 0; cyc(3, "R9");

        // R10 reload-start on either edge and direction
        cfg_rise_act = 3; trig_in = 1; cyc(7, "R10");
        trig_in = 0; cyc(3, "R10");
        cfg_mode = 1; trig_in = 1; cyc(5, "R10");
        cfg_rise_act = 0; cfg_fall_act = 3; trig_in = 0; cyc(5, "R10");
        cfg_fall_act = 0; cfg_mode = 0;

        // R11 stop wins over start, edge start vs software stop
        sw_start = 1; sw_stop = 1; cyc(3, "R11");
        cfg_rise_act = 1; trig_in = 1; sw_stop = 1; cyc(3, "R11");
        trig_in = 0; cfg_rise_act = 0; cyc(4, "R11");

        // R12 counter write while running and while stopped
        sw_start = 1; cyc(4, "R12");
        cnt_wr = 1; cnt_wdata = 2; cyc(6, "R12");
        sw_stop = 1; cyc(1, "R12");
        cnt_wr = 1; cnt_wdata = 16'h1234; cyc(1, "R12");
        chk("R12", "count", count, 16'h1234);
        chk("R12", "running", running, 0);

        // R13 reserved mode holds the count while running
        cfg_mode = 3; sw_start = 1; cyc(10, "R13");
        chk("R13", "count", count, 16'h1234);
        chk("R13", "running", running, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule